// File: doc/BRIEF.md
# Programmable Strobe Divider Bank

The block holds six independent divider channels in two 32-bit control registers, three channels per register. Each channel chooses one of the system's source enable strobes (one per PLL-derived clock), counts that strobe's pulses, and emits a one-cycle enable strobe after every D counted pulses, where D comes from an 8-bit divisor code in the channel's field. Everything runs in a single system clock domain, so downstream logic gates its work with the strobe instead of using a derived clock.

Software writes a whole control register through a simple write port and reads either register back through a combinational read port. A parameter fixes the field format. The legacy format has a one-bit source choice and a separate enable bit, with even ratios only. The extended format has a two-bit source code in which zero means off, and a scale bit in register 0 that switches every channel between even ratios and unit-step ratios. Any change to a channel's configuration restarts its count, so no strobe ever appears early.

Top module: `freq_gen_bank`

## Requirements
- R1: While `rst_n` is low, both control registers are zero, `rd_data` is zero and every bit of `div_stb` is low.
- R2: A cycle with `wr_en` high loads all 32 bits of `wr_data` into register 0 (`wr_sel`=0) or register 1 (`wr_sel`=1) at the clock edge. `rd_data` shows the register picked by `rd_sel` without delay, and it changes only when a write occurs or `rd_sel` changes.
- R3: Channel k (0..5) owns bits [10·(k mod 3)+9 : 10·(k mod 3)] of register k div 3. Within that field, bits [9:2] hold the divisor code N, and bits [1:0] hold the source and enable controls.
- R4: In the legacy format (`EXT_FMT`=0), field bit 1 enables the channel. Field bit 0 selects `cpu_stb` when 0 and `aux_stb` when 1. The ratio is D = 2·(N+1). Register 0 bit 30 has no effect.
- R5: In the extended format (`EXT_FMT`=1), field bits [1:0] select the source: 0 = channel off, 1 = `aux2_stb`, 2 = `cpu_stb`, 3 = `aux_stb`. With register 0 bit 30 set, the ratio is D = N+1 for all six channels. With that bit clear, the ratio is D = 2·(N+1).
- R6: An enabled channel raises its `div_stb` bit for exactly one cycle, in the cycle after every D-th pulse of its selected source counted since the channel last restarted. No strobe appears at any other time.
- R7: A write that changes a channel's 10-bit field restarts that channel. In the extended format, a write that changes the scale bit also restarts all six channels. On a restart, the count returns to zero and a source pulse in the write cycle is not counted. A write that leaves the field and the scale bit unchanged does not disturb the count.
- R8: A channel that is off keeps its count at zero and its `div_stb` bit low. After it is enabled again, it needs D fresh source pulses before its first strobe. Turning a channel off leaves its divisor bits as they were written.
- R9: The limits of the divisor code hold. N=255 gives a ratio of 512 in even mode and 256 in unit mode. N=0 in unit mode passes every source pulse through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register chosen for the write (0 or 1) |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Register shown on the read port |
| rd_data | output | 32 | Contents of the register chosen by `rd_sel` |
| cpu_stb | input | 1 | Enable strobe of the CPU clock source |
| aux_stb | input | 1 | Enable strobe of the first auxiliary PLL source |
| aux2_stb | input | 1 | Enable strobe of the second auxiliary PLL source (extended format only) |
| div_stb | output | 6 | Divided enable strobes, one bit per channel |

## Verification
A register write and a selected source pulse can arrive in the same cycle. When the write changes the channel's configuration, the restart must win and the pulse must be dropped. When the write leaves the configuration unchanged, the pulse must still be counted. The bench provokes this case by issuing writes while `cpu_stb` is high every cycle and the other sources pulse on their own patterns. Some of those writes change fields and some repeat a value already in the register. A behavioural model that counts pulses with integers predicts every `div_stb` bit of both formats on every clock, and the bench compares the outputs against it.

// File: rtl/freq_gen_bank.sv
module freq_gen_bank #(
  parameter bit EXT_FMT    = 1'b1,
  parameter int CH_PER_REG = 3,
  parameter int FLD_W      = 10,
  parameter int REG_W      = 32,
  parameter int SCALE_BIT  = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [REG_W-1:0]        wr_data,
  input  logic                    rd_sel,
  output logic [REG_W-1:0]        rd_data,
  input  logic                    cpu_stb,
  input  logic                    aux_stb,
  input  logic                    aux2_stb,
  output logic [2*CH_PER_REG-1:0] div_stb
);
  localparam int NCH   = 2 * CH_PER_REG;
  localparam int DIV_W = FLD_W - 2;
  localparam int CNT_W = DIV_W + 1;

  logic [REG_W-1:0] ctl0, ctl1, nxt0, nxt1;
  logic             scl, nscl;

  assign nxt0 = (wr_en && !wr_sel) ? wr_data : ctl0;
  assign nxt1 = (wr_en &&  wr_sel) ? wr_data : ctl1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0;
      ctl1 <= '0;
    end else begin
      ctl0 <= nxt0;
      ctl1 <= nxt1;
    end
  end

  assign rd_data = rd_sel ? ctl1 : ctl0;
  assign scl     = EXT_FMT & ctl0[SCALE_BIT];
  assign nscl    = EXT_FMT & nxt0[SCALE_BIT];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int OFF = FLD_W * (k % CH_PER_REG);
    logic [FLD_W-1:0] fld, nfld;
    logic             on, sel, restart, out_q;
    logic [CNT_W-1:0] cnt, last;

    assign fld  = (k < CH_PER_REG) ? ctl0[OFF +: FLD_W] : ctl1[OFF +: FLD_W];
    assign nfld = (k < CH_PER_REG) ? nxt0[OFF +: FLD_W] : nxt1[OFF +: FLD_W];

    if (EXT_FMT) begin : g_ext
      assign on = (fld[1:0] != 2'd0);
      always_comb begin
        case (fld[1:0])
          2'd1:    sel = aux2_stb;
          2'd2:    sel = cpu_stb;
          2'd3:    sel = aux_stb;
          default: sel = 1'b0;
        endcase
      end
    end else begin : g_leg
      assign on  = fld[1];
      assign sel = fld[0] ? aux_stb : cpu_stb;
    end

    assign last    = scl ? {1'b0, fld[FLD_W-1:2]} : {fld[FLD_W-1:2], 1'b1};
    assign restart = (fld != nfld) || (scl != nscl);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt   <= '0;
        out_q <= 1'b0;
      end else if (restart || !on) begin
        cnt   <= '0;
        out_q <= 1'b0;
      end else if (sel) begin
        if (cnt == last) begin
          cnt   <= '0;
          out_q <= 1'b1;
        end else begin
          cnt   <= cnt + 1'b1;
          out_q <= 1'b0;
        end
      end else begin
        out_q <= 1'b0;
      end
    end

    assign div_stb[k] = out_q;
  end
endmodule

// File: rtl/fgb_checker.sv
module fgb_checker #(
  parameter bit EXT_FMT = 1'b1,
  parameter int REG_W   = 32,
  parameter int NCH     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             cpu_stb,
  input logic             aux_stb,
  input logic             aux2_stb,
  input logic [NCH-1:0]   div_stb
);
  logic ch0_off_wr;
  assign ch0_off_wr = EXT_FMT ? (wr_data[1:0] == 2'd0) : !wr_data[1];

  a_r2_readback_reg0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(wr_sel) && !rd_sel) |-> rd_data == $past(wr_data));

  a_r2_readback_reg1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_sel) && rd_sel) |-> rd_data == $past(wr_data));

  a_r2_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(rd_sel)) |-> $stable(rd_data));

  a_r6_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|div_stb) |-> $past(cpu_stb || aux_stb || aux2_stb));

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && ch0_off_wr) |=> !div_stb[0]);

  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !rd_sel && (wr_data[9:0] != rd_data[9:0])) |=> !div_stb[0]);
endmodule

bind freq_gen_bank fgb_checker #(.EXT_FMT(EXT_FMT), .REG_W(REG_W), .NCH(2*CH_PER_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .cpu_stb(cpu_stb), .aux_stb(aux_stb),
  .aux2_stb(aux2_stb), .div_stb(div_stb)
);

// File: tb/sim_freq_gen_bank.sv
module sim_freq_gen_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cpu_stb = 1'b0, aux_stb = 1'b0, aux2_stb = 1'b0;
  logic [31:0] rd0, rd1;
  logic [5:0]  stb0, stb1;

  always #10 clk = ~clk;

  freq_gen_bank #(.EXT_FMT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd0), .cpu_stb(cpu_stb), .aux_stb(aux_stb),
    .aux2_stb(aux2_stb), .div_stb(stb0));

  freq_gen_bank #(.EXT_FMT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd1), .cpu_stb(cpu_stb), .aux_stb(aux_stb),
    .aux2_stb(aux2_stb), .div_stb(stb1));

  int          n_chk = 0, n_bad = 0, cyc = 0;
  string       cur_req = "R1";
  bit          cpu_always = 1'b1;
  logic [31:0] mr [2];
  int          mc [2][6];
  logic [5:0]  exp_stb [2];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] n0, input logic [31:0] n1);
    logic [31:0] nr [2];
    nr[0] = n0; nr[1] = n1;
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 6; k++) begin
        int rg, off, fld, nfld, nn, d;
        bit scl, nscl, on, sel;
        rg = k / 3; off = 10 * (k % 3);
        fld  = (mr[rg] >> off) & 1023;
        nfld = (nr[rg] >> off) & 1023;
        scl  = (f == 1) && mr[0][30];
        nscl = (f == 1) && nr[0][30];
        if (f == 0) begin
          on  = fld[1];
          sel = fld[0] ? aux_stb : cpu_stb;
        end else begin
          on = (fld & 3) != 0;
          case (fld & 3)
            1: sel = aux2_stb;
            2: sel = cpu_stb;
            3: sel = aux_stb;
            default: sel = 1'b0;
          endcase
        end
        nn = fld >> 2;
        d  = scl ? nn + 1 : 2 * (nn + 1);
        exp_stb[f][k] = 1'b0;
        if (fld != nfld || scl != nscl || !on) mc[f][k] = 0;
        else if (sel) begin
          mc[f][k]++;
          if (mc[f][k] == d) begin
            mc[f][k] = 0;
            exp_stb[f][k] = 1'b1;
          end
        end
      end
    end
    mr[0] = n0; mr[1] = n1;
  endtask

  task automatic tick(input bit we, input bit ws, input logic [31:0] wd, input bit rs);
    logic [31:0] n0, n1;
    cyc++;
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    cpu_stb  = cpu_always ? 1'b1 : 1'($urandom_range(0, 1));
    aux_stb  = (cyc % 3) == 0;
    aux2_stb = 1'($urandom_range(0, 1));
    n0 = (we && !ws) ? wd : mr[0];
    n1 = (we &&  ws) ? wd : mr[1];
    model(n0, n1);
    @(negedge clk);
    chk(cur_req, "legacy strobes", {26'd0, stb0}, {26'd0, exp_stb[0]});
    chk(cur_req, "extended strobes", {26'd0, stb1}, {26'd0, exp_stb[1]});
    chk("R2", "legacy readback", rd0, mr[rs]);
    chk("R2", "extended readback", rd1, mr[rs]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic wr(input bit ws, input logic [31:0] wd);
    tick(1'b1, ws, wd, ws);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    mr[0] = '0; mr[1] = '0;
    for (int f = 0; f < 2; f++) begin
      exp_stb[f] = '0;
      for (int k = 0; k < 6; k++) mc[f][k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "legacy strobes in reset", {26'd0, stb0}, 32'd0);
    chk("R1", "extended strobes in reset", {26'd0, stb1}, 32'd0);
    chk("R1", "legacy reg in reset", rd0, 32'd0);
    chk("R1", "extended reg in reset", rd1, 32'd0);
    rst_n = 1'b1;
    idle(5);

    cur_req = "R4";
    wr(1'b0, 32'h0000_0002);
    idle(20);
    wr(1'b0, 32'h0000_0007);
    idle(30);

    cur_req = "R5";
    wr(1'b1, 32'h0000_0009);
    idle(30);
    wr(1'b0, 32'h4000_000A);
    idle(30);
    wr(1'b0, 32'h0000_0003);
    idle(30);

    cur_req = "R3";
    wr(1'b0, 32'h4000_0000 | (32'h00B << 10) | (32'h00E << 20) | 32'h006);
    wr(1'b1, (32'h013 << 10) | (32'h00D << 20) | 32'h00A);
    idle(60);

    cur_req = "R7";
    cpu_always = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wr(1'b0, (i % 3 == 0) ? mr[0] : (mr[0] ^ 32'h0000_0010));
      idle(i % 4);
    end
    wr(1'b0, 32'h0000_000A);
    idle(3);
    wr(1'b0, 32'h0000_000A);
    idle(10);
    wr(1'b0, 32'h4000_000A);
    idle(5);

    cur_req = "R8";
    wr(1'b0, 32'h0000_0008);
    idle(10);
    chk("R8", "divisor kept while off", rd0, 32'h0000_0008);
    wr(1'b0, 32'h0000_000A);
    idle(20);

    cur_req = "R9";
    wr(1'b0, 32'h0000_03FE);
    idle(1100);
    wr(1'b0, 32'h4000_03FE);
    idle(600);
    wr(1'b0, 32'h4000_0002);
    idle(10);

    cur_req = "R6";
    cpu_always = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0)
        tick(1'b1, 1'($urandom_range(0, 1)), $urandom() & 32'h7FFF_FFFF, 1'($urandom_range(0, 1)));
      else
        tick(1'b0, 1'b0, 32'd0, 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule